// File: doc/BRIEF.md
# Vector Length State and Element Loop Sequencer

This block keeps the vector-length configuration of a parallel execution unit in one packed 32-bit state word and walks a two-level element loop over it. The outer level counts elements from 0 to VL-1; beneath it, a sub-vector level counts 0 to SUBVL-1 for every element. The outer level waits until the inner level has covered all of its positions. Each `step` pulse issues one sub-element. The block presents the current destination offset, source offset and sub-vector offset, and it flags the end of the whole loop.

Configuration arrives as control-register writes. A write selects the maximum length, the length, the sub-vector count or the whole state word. Lengths are held minus one, so a 6-bit field covers 1 to 64. Out-of-range lengths are clamped without any signal. An out-of-range sub-vector count is refused and reported. The read port returns the value that a write actually took.

For trap handling, a trap-entry pulse exchanges the live state with a saved copy. A trap-return pulse exchanges them back, so an interrupted loop resumes at the exact offsets it had.

Top module: `vl_loop_seq`

## Requirements
- R1: After reset the state word is 0x00000000, so the maximum length, the length and the sub-vector count all read back as 1, and `done` and `illegal` are low.
- R2: The state word places the maximum length minus one in bits 5:0, the length minus one in 11:6, the source offset in 17:12, the destination offset in 23:18, the sub-vector count minus one in 25:24 and the sub-vector offset in 27:26. Bits 31:28 always read zero.
- R3: A write with `csr_sel`=0 sets the maximum length to the request clamped to 1..XLEN. If the length is now above the new maximum, the length drops to the new maximum.
- R4: A write with `csr_sel`=1 sets the length to the request clamped to 1..maximum length. A request of 0 gives 1. In the next cycle `rd_data` with `csr_sel`=1 returns the stored length.
- R5: When `wr_imm` is high, a length or maximum-length write takes its request from `wr_data[4:0]` plus one before clamping.
- R6: A write with `csr_sel`=2 and a value of 1..4 sets the sub-vector count to that value. Any other value leaves the state word unchanged and raises `illegal` for exactly the following cycle.
- R7: Each `step` advances the sub-vector offset first. The destination and source offsets advance together, and only when the sub-vector offset wraps from count-1 back to 0.
- R8: The step that issues sub-element count-1 of element length-1 returns all three offsets to 0. It also raises `done` for exactly one cycle.
- R9: A `trap_enter` or `trap_exit` pulse exchanges the live state word with the saved one. Entering and then returning restores the interrupted offsets, and stepping then continues from them.
- R10: A write with `csr_sel`=3 loads the whole word with these corrections: reserved bits are cleared, the maximum-length field is limited to XLEN-1, and the length field is limited to the maximum-length field. Any offset beyond its current range is set to 0. The same offset correction follows every write.
- R11: A trap pulse takes precedence over a write, and a write takes precedence over `step`. A step that coincides with a write leaves the offsets unadvanced.
- R12: `rd_data` returns the maximum length, the length, the sub-vector count (all as true values) or the whole state word for `csr_sel` 0, 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_sel | input | 2 | Register select for write and read: 0 max length, 1 length, 2 sub-vector count, 3 state word |
| wr_en | input | 1 | Write strobe |
| wr_imm | input | 1 | Immediate form: length request is wr_data[4:0]+1 |
| wr_data | input | 32 | Write value |
| rd_data | output | 32 | Read value of the selected register |
| illegal | output | 1 | One-cycle pulse after a refused sub-vector count |
| step | input | 1 | Issue one sub-element |
| trap_enter | input | 1 | Swap live and saved state on trap entry |
| trap_exit | input | 1 | Swap live and saved state on trap return |
| state_word | output | 32 | Live packed state word |
| dest_offs | output | 6 | Current destination element offset |
| src_offs | output | 6 | Current source element offset |
| sub_offs | output | 2 | Current sub-vector offset |
| done | output | 1 | One-cycle pulse after the final sub-element |

## Verification
The bench builds the block with XLEN set to 16 rather than the default 64. This brings the upper clamp within reach of both ordinary register writes and the largest immediate (31+1=32). It also makes the whole-word write of all ones exercise the maximum-length limit at field value 15. With a length of 3 and a sub-vector count of 2, the full nested walk and its wrap take six steps, so every step is checked against counts computed in the bench.

// File: rtl/vlseq_pkg.sv
package vlseq_pkg;

    localparam int FIELD_W  = 6;
    localparam int SUB_W    = 2;
    localparam int WORD_W   = 32;
    localparam int SUB_MAX  = 1 << SUB_W;

    // Packed layout, MSB first: reserved, sub offset, sub count-1,
    // destination offset, source offset, length-1, max length-1.
    typedef struct packed {
        logic [3:0]         rsvd;
        logic [SUB_W-1:0]   svo;
        logic [SUB_W-1:0]   subcnt;
        logic [FIELD_W-1:0] dst;
        logic [FIELD_W-1:0] src;
        logic [FIELD_W-1:0] len;
        logic [FIELD_W-1:0] maxlen;
    } vstate_t;

    typedef enum logic [1:0] {
        SEL_MAXLEN = 2'd0,
        SEL_LEN    = 2'd1,
        SEL_SUBCNT = 2'd2,
        SEL_WORD   = 2'd3
    } csr_sel_e;

endpackage

// File: rtl/vlseq_len_clamp.sv
// Turns a requested length into a minus-one field bounded by a ceiling field.
module vlseq_len_clamp #(
    parameter int REQ_W = 32,
    parameter int FW    = 6
) (
    input  logic [REQ_W-1:0] req_len,
    input  logic [FW-1:0]    ceil_field,
    output logic [FW-1:0]    len_field
);

    logic [REQ_W-1:0] ceil_len;
    logic [REQ_W-1:0] req_m1;

    assign ceil_len = REQ_W'(ceil_field) + REQ_W'(1);
    assign req_m1   = req_len - REQ_W'(1);

    always_comb begin
        if (req_len == '0) begin
            len_field = '0;
        end else if (req_len > ceil_len) begin
            len_field = ceil_field;
        end else begin
            len_field = FW'(req_m1);
        end
    end

endmodule

// File: rtl/vlseq_sanitize.sv
// Brings any candidate state word back into its legal ranges.
module vlseq_sanitize
    import vlseq_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  vstate_t raw,
    output vstate_t clean
);

    localparam logic [FIELD_W-1:0] MAX_FIELD = FIELD_W'(XLEN - 1);

    logic [FIELD_W-1:0] maxlen_c;
    logic [FIELD_W-1:0] len_c;

    assign maxlen_c = (raw.maxlen > MAX_FIELD) ? MAX_FIELD : raw.maxlen;
    assign len_c    = (raw.len > maxlen_c) ? maxlen_c : raw.len;

    always_comb begin
        clean        = raw;
        clean.rsvd   = '0;
        clean.maxlen = maxlen_c;
        clean.len    = len_c;
        if (raw.src > len_c) begin
            clean.src = '0;
        end
        if (raw.dst > len_c) begin
            clean.dst = '0;
        end
        if (raw.svo > raw.subcnt) begin
            clean.svo = '0;
        end
    end

endmodule

// File: rtl/vlseq_stepper.sv
// One issue of the nested loop: inner sub-vector level first, then elements.
module vlseq_stepper
    import vlseq_pkg::*;
(
    input  vstate_t cur,
    output vstate_t nxt,
    output logic    wrap
);

    logic sub_last;
    logic elem_last;

    assign sub_last  = (cur.svo == cur.subcnt);
    assign elem_last = (cur.dst >= cur.len);

    always_comb begin
        nxt  = cur;
        wrap = 1'b0;
        if (!sub_last) begin
            nxt.svo = cur.svo + SUB_W'(1);
        end else begin
            nxt.svo = '0;
            if (elem_last) begin
                nxt.dst = '0;
                nxt.src = '0;
                wrap    = 1'b1;
            end else begin
                nxt.dst = cur.dst + FIELD_W'(1);
                nxt.src = cur.src + FIELD_W'(1);
            end
        end
    end

endmodule

// File: rtl/vl_loop_seq.sv
module vl_loop_seq
    import vlseq_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  csr_sel,
    input  logic        wr_en,
    input  logic        wr_imm,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        illegal,
    input  logic        step,
    input  logic        trap_enter,
    input  logic        trap_exit,
    output logic [31:0] state_word,
    output logic [5:0]  dest_offs,
    output logic [5:0]  src_offs,
    output logic [1:0]  sub_offs,
    output logic        done
);

    localparam logic [FIELD_W-1:0] MAX_FIELD = FIELD_W'(XLEN - 1);

    typedef struct packed {
        vstate_t live;
        vstate_t saved;
        logic    done;
        logic    ill;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [WORD_W-1:0]  req_len;
    logic [FIELD_W-1:0] maxlen_new;
    logic [FIELD_W-1:0] len_new;
    logic               sub_ok;
    vstate_t            cand;
    vstate_t            cand_clean;
    vstate_t            stepped;
    logic               step_wrap;
    csr_sel_e           sel;

    assign sel     = csr_sel_e'(csr_sel);
    assign req_len = wr_imm ? (WORD_W'(wr_data[4:0]) + WORD_W'(1)) : wr_data;
    assign sub_ok  = (wr_data >= 32'd1) && (wr_data <= 32'(SUB_MAX));

    vlseq_len_clamp #(.REQ_W(WORD_W), .FW(FIELD_W)) u_maxlen_clamp (
        .req_len    (req_len),
        .ceil_field (MAX_FIELD),
        .len_field  (maxlen_new)
    );

    vlseq_len_clamp #(.REQ_W(WORD_W), .FW(FIELD_W)) u_len_clamp (
        .req_len    (req_len),
        .ceil_field (regs_q.live.maxlen),
        .len_field  (len_new)
    );

    always_comb begin
        cand = regs_q.live;
        case (sel)
            SEL_MAXLEN: cand.maxlen = maxlen_new;
            SEL_LEN:    cand.len    = len_new;
            SEL_SUBCNT: if (sub_ok) cand.subcnt = SUB_W'(wr_data - 32'd1);
            default:    cand = vstate_t'(wr_data);
        endcase
    end

    vlseq_sanitize #(.XLEN(XLEN)) u_sanitize (
        .raw   (cand),
        .clean (cand_clean)
    );

    vlseq_stepper u_stepper (
        .cur  (regs_q.live),
        .nxt  (stepped),
        .wrap (step_wrap)
    );

    // Next-state: trap swap, then write, then step.
    always_comb begin
        regs_d      = regs_q;
        regs_d.done = 1'b0;
        regs_d.ill  = 1'b0;
        if (trap_enter || trap_exit) begin
            regs_d.live  = regs_q.saved;
            regs_d.saved = regs_q.live;
        end else if (wr_en) begin
            if ((sel == SEL_SUBCNT) && !sub_ok) begin
                regs_d.ill = 1'b1;
            end else begin
                regs_d.live = cand_clean;
            end
        end else if (step) begin
            regs_d.live = stepped;
            regs_d.done = step_wrap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (sel)
            SEL_MAXLEN: rd_data = WORD_W'(regs_q.live.maxlen) + WORD_W'(1);
            SEL_LEN:    rd_data = WORD_W'(regs_q.live.len) + WORD_W'(1);
            SEL_SUBCNT: rd_data = WORD_W'(regs_q.live.subcnt) + WORD_W'(1);
            default:    rd_data = regs_q.live;
        endcase
    end

    assign state_word = regs_q.live;
    assign dest_offs  = regs_q.live.dst;
    assign src_offs   = regs_q.live.src;
    assign sub_offs   = regs_q.live.svo;
    assign done       = regs_q.done;
    assign illegal    = regs_q.ill;

endmodule

// File: rtl/vlseq_check.sv
module vlseq_check #(
    parameter int XLEN = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        step,
    input logic        trap_enter,
    input logic        trap_exit,
    input logic        illegal,
    input logic [31:0] state_word,
    input logic [5:0]  dest_offs,
    input logic [5:0]  src_offs,
    input logic [1:0]  sub_offs,
    input logic        done
);

    localparam logic [5:0] MAX_FIELD = 6'(XLEN - 1);

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_word[31:28] == 4'd0);

    assert_maxlen_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state_word[5:0] <= MAX_FIELD);

    assert_len_under_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_word[11:6] <= state_word[5:0]);

    assert_refused_keeps_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (state_word == $past(state_word)));

    assert_inner_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_en && !trap_enter && !trap_exit && (sub_offs != state_word[25:24]))
        |=> (sub_offs == $past(sub_offs) + 2'd1) && (dest_offs == $past(dest_offs)));

    assert_done_offsets_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dest_offs == 6'd0 && src_offs == 6'd0 && sub_offs == 2'd0));

    assert_write_blocks_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !trap_enter && !trap_exit) |=> !done);

endmodule

bind vl_loop_seq vlseq_check #(.XLEN(XLEN)) u_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .step       (step),
    .trap_enter (trap_enter),
    .trap_exit  (trap_exit),
    .illegal    (illegal),
    .state_word (state_word),
    .dest_offs  (dest_offs),
    .src_offs   (src_offs),
    .sub_offs   (sub_offs),
    .done       (done)
);

// File: tb/sim_vl_loop_seq.sv
`timescale 1ns/1ps
module sim_vl_loop_seq;

    localparam int XLEN = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  csr_sel = 2'd0;
    logic        wr_en = 1'b0;
    logic        wr_imm = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        illegal;
    logic        step = 1'b0;
    logic        trap_enter = 1'b0;
    logic        trap_exit = 1'b0;
    logic [31:0] state_word;
    logic [5:0]  dest_offs;
    logic [5:0]  src_offs;
    logic [1:0]  sub_offs;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    vl_loop_seq #(.XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .wr_en(wr_en),
        .wr_imm(wr_imm), .wr_data(wr_data), .rd_data(rd_data),
        .illegal(illegal), .step(step), .trap_enter(trap_enter),
        .trap_exit(trap_exit), .state_word(state_word),
        .dest_offs(dest_offs), .src_offs(src_offs), .sub_offs(sub_offs),
        .done(done)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic        imm;
        logic [31:0] data;
        logic [1:0]  rsel;
        logic [31:0] exp;
        logic        ill;
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 1'b0, 32'd8,          2'd0, 32'd8,          1'b0}, // R3
        '{2'd1, 1'b0, 32'd5,          2'd1, 32'd5,          1'b0}, // R4
        '{2'd1, 1'b0, 32'd12,         2'd1, 32'd8,          1'b0}, // R4 clamp to max
        '{2'd1, 1'b0, 32'd0,          2'd1, 32'd1,          1'b0}, // R4 zero -> 1
        '{2'd0, 1'b0, 32'd40,         2'd0, 32'd16,         1'b0}, // R3 clamp XLEN
        '{2'd0, 1'b0, 32'd0,          2'd0, 32'd1,          1'b0}, // R3 zero -> 1
        '{2'd0, 1'b1, 32'd15,         2'd0, 32'd16,         1'b0}, // R5
        '{2'd1, 1'b1, 32'd3,          2'd1, 32'd4,          1'b0}, // R5
        '{2'd1, 1'b1, 32'd31,         2'd1, 32'd16,         1'b0}, // R5 clamp
        '{2'd0, 1'b0, 32'd10,         2'd1, 32'd10,         1'b0}, // R3 pulls length
        '{2'd2, 1'b0, 32'd3,          2'd2, 32'd3,          1'b0}, // R6
        '{2'd2, 1'b0, 32'd0,          2'd2, 32'd3,          1'b1}, // R6 refused
        '{2'd2, 1'b0, 32'd5,          2'd2, 32'd3,          1'b1}, // R6 refused
        '{2'd2, 1'b0, 32'd4,          2'd2, 32'd4,          1'b0}, // R6
        '{2'd3, 1'b0, 32'hFFFF_FFFF,  2'd3, 32'h0F00_03CF,  1'b0}, // R10
        '{2'd3, 1'b0, 32'h0508_20C7,  2'd3, 32'h0508_20C7,  1'b0}, // R2 R10
        '{2'd3, 1'b0, 32'h0014_0244,  2'd3, 32'h0000_0104,  1'b0}  // R10
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] sel, input logic imm, input logic [31:0] data);
        @(negedge clk);
        csr_sel = sel; wr_imm = imm; wr_data = data; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_imm = 1'b0;
    endtask

    task automatic do_step();
        @(negedge clk);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 word", state_word, 32'h0);
        csr_sel = 2'd0; #1;
        check("R1 maxlen", rd_data, 32'd1);
        csr_sel = 2'd2; #1;
        check("R1 subcnt", rd_data, 32'd1);
        check("R1 done", {31'b0, done}, 32'd0);
        check("R1 illegal", {31'b0, illegal}, 32'd0);

        // Table of writes and read-backs (R3 R4 R5 R6 R10 R12)
        for (int i = 0; i < NVEC; i++) begin
            do_write(VECS[i].sel, VECS[i].imm, VECS[i].data);
            csr_sel = VECS[i].rsel; #1;
            check($sformatf("R12 vec%0d read", i), rd_data, VECS[i].exp);
            check($sformatf("R6 vec%0d illegal", i), {31'b0, illegal}, {31'b0, VECS[i].ill});
        end
        @(negedge clk);
        check("R6 illegal one cycle", {31'b0, illegal}, 32'd0);

        // Nested loop: length 3, sub-vector count 2 (R7 R8)
        do_write(2'd0, 1'b0, 32'd3);
        csr_sel = 2'd1; #1;
        check("R3 length follows max", rd_data, 32'd3);
        do_write(2'd2, 1'b0, 32'd2);
        for (int k = 1; k <= 6; k++) begin
            do_step();
            check($sformatf("R7 step%0d sub", k), {30'b0, sub_offs}, 32'(k % 2));
            check($sformatf("R7 step%0d dest", k), {26'b0, dest_offs}, 32'((k / 2) % 3));
            check($sformatf("R7 step%0d src", k), {26'b0, src_offs}, 32'((k / 2) % 3));
            check($sformatf("R8 step%0d done", k), {31'b0, done}, (k == 6) ? 32'd1 : 32'd0);
        end
        @(negedge clk);
        check("R8 done one cycle", {31'b0, done}, 32'd0);

        // R11: write wins over a coincident step
        @(negedge clk);
        csr_sel = 2'd1; wr_data = 32'd3; wr_en = 1'b1; step = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; step = 1'b0;
        check("R11 step held by write", {30'b0, sub_offs}, 32'd0);

        // R9 trap swap and resume
        repeat (3) do_step();
        check("R9 pre dest", {26'b0, dest_offs}, 32'd1);
        check("R9 pre sub", {30'b0, sub_offs}, 32'd1);
        @(negedge clk);
        trap_enter = 1'b1; wr_en = 1'b1; csr_sel = 2'd1; wr_data = 32'd2;
        @(negedge clk);
        trap_enter = 1'b0; wr_en = 1'b0;
        check("R9 R11 trap state", state_word, 32'h0);
        do_write(2'd0, 1'b0, 32'd7);
        @(negedge clk);
        trap_exit = 1'b1;
        @(negedge clk);
        trap_exit = 1'b0;
        check("R9 resume dest", {26'b0, dest_offs}, 32'd1);
        check("R9 resume sub", {30'b0, sub_offs}, 32'd1);
        csr_sel = 2'd1; #1;
        check("R9 resume length", rd_data, 32'd3);
        do_step();
        check("R9 continue dest", {26'b0, dest_offs}, 32'd2);
        check("R9 continue sub", {30'b0, sub_offs}, 32'd0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule